// File: doc/BRIEF.md
# Field Counter and 50/60 Standard Decoder

This block keeps the vertical timebase of a television sync processor. A 10-bit counter advances once per half-line tick and is cleared by each qualified vertical sync pulse. The count reached at that moment gives the field length in half-lines. The block compares this length against a threshold and latches a 50 Hz or 60 Hz flag. If no vertical sync arrives, the counter wraps by itself after 625 half-lines, so the vertical timebase keeps running.

The block produces two timing outputs from the count and the flag:

- **Vertical drive pulse.** A small state machine generates it. The states are `VP_IDLE`, `VP_DELAY` and `VP_PULSE`.
  - A field start moves the machine from any state to `VP_DELAY`.
  - After the delay ticks, `VP_DELAY` moves to `VP_PULSE`.
  - After the pulse-length ticks, `VP_PULSE` moves to `VP_IDLE`.
  - `VP_IDLE` stays where it is until the next field start.
- **Sandcastle code.** This is a 2-bit code with three active levels, taken from three sources:
  - the horizontal blanking window, decoded from the line position count;
  - the burst-key window, whose width depends on the standard;
  - a vertical-blank flag, which is sampled once per line at the line-start strobe.

The parameter values are in half-lines for vertical timing and in line-position units for horizontal timing. One line-position unit stands for 0.1 µs, so the defaults give 11.8 µs of horizontal blank and a burst key that starts at 2.5 µs. The burst key lasts 4.3 µs at 50 Hz and 3.8 µs at 60 Hz.

Top module: `vfield_timer`

## Requirements
- R1: The half-line count rises by one on each cycle with `hl_tick` high and is never 625 or more. A field of exactly 574 ticks and a field of exactly 575 ticks are told apart by R3.
- R2: `vsync_q` clears the count to 0 in the next cycle. A `hl_tick` in the same cycle is not counted.
- R3: At each `vsync_q`, `std50` becomes 1 when the count at that moment is 575 or more, and 0 otherwise. It keeps its value between field starts and is 1 after reset.
- R4: A tick at count 624 with no `vsync_q` wraps the count to 0. It sets `std50` to 1, records 625 as the field length, and counts as a field start for R5.
- R5: After a field start, `vdrive` goes high in the cycle after the 1st following tick. It stays high for 10 ticks and is then low. A field start always forces it low and restarts the delay.
- R6: `sc_code` is registered one cycle after `hpos`. The encoding is 00 for low, 01 for vertical blank, 10 for horizontal blank and 11 for burst key. It is 00 after reset.
- R7: When `hpos` < 118, the code is at least horizontal blank (10).
- R8: When 25 ≤ `hpos` < 25+W, the code is burst key (11). W is 43 when `std50`=1 and 38 when `std50`=0.
- R9: At each `line_start`, the vertical-blank flag is loaded from the count C and the last field length P. At 50 Hz it is set when C < 45 or C+5 ≥ P. At 60 Hz it is set when C < 34 or C+6 ≥ P. The flag is held until the next `line_start`, and it gives code 01 when no horizontal level is active.
- R10: Priority is burst key over horizontal blank over vertical blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hl_tick | input | 1 | Half-line tick, one cycle wide |
| line_start | input | 1 | Line-start strobe |
| hpos | input | 10 | Position within the line |
| vsync_q | input | 1 | Qualified vertical sync, one cycle wide |
| vdrive | output | 1 | Vertical drive pulse |
| std50 | output | 1 | 1 = 50 Hz field, 0 = 60 Hz field |
| sc_code | output | 2 | Sandcastle level code |

## Verification
`std50` and the count take effect one cycle after the `vsync_q` or tick that changes them. `vdrive` changes one cycle after the tick that ends its delay or pulse period. `sc_code` follows `hpos` with one register. The vertical-blank part of `sc_code` lags `line_start` by two cycles: one cycle to load the flag and one cycle to encode it. The bench drives inputs on the falling edge and advances a cycle model at each rising edge. It compares the outputs at the next falling edge, so every comparison lands in the cycle where the result is due.

// File: rtl/vft_pkg.sv
package vft_pkg;

    typedef enum logic [1:0] {
        VP_IDLE  = 2'd0,
        VP_DELAY = 2'd1,
        VP_PULSE = 2'd2
    } vpulse_state_e;

    typedef enum logic [1:0] {
        SC_LOW    = 2'b00,
        SC_VBLANK = 2'b01,
        SC_HBLANK = 2'b10,
        SC_BURST  = 2'b11
    } sc_level_e;

endpackage

// File: rtl/vft_halfline_counter.sv
module vft_halfline_counter #(
    parameter int CNT_W      = 10,
    parameter int WRAP       = 625,
    parameter int STD_THRESH = 575
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hl_tick,
    input  logic             vsync_q,
    output logic [CNT_W-1:0] hl_cnt,
    output logic [CNT_W-1:0] prev_len,
    output logic             std50,
    output logic             field_start
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WRAP - 1);
    localparam logic [CNT_W-1:0] WRAP_LEN = CNT_W'(WRAP);
    localparam logic [CNT_W-1:0] THRESH   = CNT_W'(STD_THRESH);

    logic wrap_hit;

    always_comb begin
        wrap_hit    = hl_tick && !vsync_q && (hl_cnt == LAST_CNT);
        field_start = vsync_q || wrap_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hl_cnt   <= '0;
            prev_len <= WRAP_LEN;
            std50    <= 1'b1;
        end else if (vsync_q) begin
            prev_len <= hl_cnt;
            std50    <= (hl_cnt >= THRESH);
            hl_cnt   <= '0;
        end else if (hl_tick) begin
            if (hl_cnt == LAST_CNT) begin
                hl_cnt   <= '0;
                prev_len <= WRAP_LEN;
                std50    <= 1'b1;
            end else begin
                hl_cnt <= hl_cnt + 1'b1;
            end
        end
    end

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hl_cnt < WRAP_LEN);

    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hl_tick && !vsync_q && hl_cnt != LAST_CNT) |=> (hl_cnt == $past(hl_cnt) + 1'b1));

    assert_vsync_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_q |=> (hl_cnt == '0));

    assert_std_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_q |=> (std50 == ($past(hl_cnt) >= THRESH)));

    assert_std_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> $stable(std50));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_hit |=> (std50 && hl_cnt == '0 && prev_len == WRAP_LEN));

endmodule

// File: rtl/vft_vpulse_fsm.sv
module vft_vpulse_fsm
    import vft_pkg::*;
#(
    parameter int VD_DELAY_HL = 1,
    parameter int VD_LEN_HL   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hl_tick,
    input  logic field_start,
    output logic vdrive
);

    localparam int MAX_HL = (VD_DELAY_HL > VD_LEN_HL) ? VD_DELAY_HL : VD_LEN_HL;
    localparam int TC_W   = $clog2(MAX_HL + 1);
    localparam logic [TC_W-1:0] DLY_LAST = TC_W'(VD_DELAY_HL - 1);
    localparam logic [TC_W-1:0] LEN_LAST = TC_W'(VD_LEN_HL - 1);

    vpulse_state_e     state, state_nx;
    logic [TC_W-1:0]   tcnt, tcnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= VP_IDLE;
            tcnt  <= '0;
        end else begin
            state <= state_nx;
            tcnt  <= tcnt_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        tcnt_nx  = tcnt;
        if (field_start) begin
            state_nx = VP_DELAY;
            tcnt_nx  = '0;
        end else begin
            unique case (state)
                VP_IDLE: begin
                    tcnt_nx = '0;
                end
                VP_DELAY: begin
                    if (hl_tick) begin
                        if (tcnt == DLY_LAST) begin
                            state_nx = VP_PULSE;
                            tcnt_nx  = '0;
                        end else begin
                            tcnt_nx = tcnt + 1'b1;
                        end
                    end
                end
                VP_PULSE: begin
                    if (hl_tick) begin
                        if (tcnt == LEN_LAST) begin
                            state_nx = VP_IDLE;
                            tcnt_nx  = '0;
                        end else begin
                            tcnt_nx = tcnt + 1'b1;
                        end
                    end
                end
                default: begin
                    state_nx = VP_IDLE;
                    tcnt_nx  = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        vdrive = (state == VP_PULSE);
    end

    assert_vd_rise_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vdrive) |-> $past(hl_tick));

    assert_vd_fall_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(vdrive) && !$past(field_start)) |-> $past(hl_tick));

    assert_fs_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> (!vdrive && state == VP_DELAY));

    assert_state_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'd3);

endmodule

// File: rtl/vft_sandcastle.sv
module vft_sandcastle
    import vft_pkg::*;
#(
    parameter int HPOS_W    = 10,
    parameter int CNT_W     = 10,
    parameter int HB_LEN    = 118,
    parameter int BK_START  = 25,
    parameter int BK_LEN50  = 43,
    parameter int BK_LEN60  = 38,
    parameter int VB_POST50 = 45,
    parameter int VB_PRE50  = 5,
    parameter int VB_POST60 = 34,
    parameter int VB_PRE60  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [HPOS_W-1:0] hpos,
    input  logic [CNT_W-1:0]  hl_cnt,
    input  logic [CNT_W-1:0]  prev_len,
    input  logic              std50,
    output logic [1:0]        sc_code
);

    localparam int SUM_W = CNT_W + 1;
    localparam int POS_W = HPOS_W + 1;

    logic [SUM_W-1:0] cnt_ext, prev_ext, post_lim, pre_amt;
    logic [POS_W-1:0] pos_ext, bk_end;
    logic             in_post, in_pre, vb_now, vblank_q;
    logic             in_hb, in_bk;
    sc_level_e        level;

    always_comb begin
        cnt_ext  = {1'b0, hl_cnt};
        prev_ext = {1'b0, prev_len};
        post_lim = std50 ? SUM_W'(VB_POST50) : SUM_W'(VB_POST60);
        pre_amt  = std50 ? SUM_W'(VB_PRE50)  : SUM_W'(VB_PRE60);
        in_post  = (cnt_ext < post_lim);
        in_pre   = ((cnt_ext + pre_amt) >= prev_ext);
        vb_now   = in_post || in_pre;
    end

    always_comb begin
        pos_ext = {1'b0, hpos};
        bk_end  = POS_W'(BK_START) + (std50 ? POS_W'(BK_LEN50) : POS_W'(BK_LEN60));
        in_hb   = (pos_ext < POS_W'(HB_LEN));
        in_bk   = (pos_ext >= POS_W'(BK_START)) && (pos_ext < bk_end);
    end

    always_comb begin
        if (in_bk)         level = SC_BURST;
        else if (in_hb)    level = SC_HBLANK;
        else if (vblank_q) level = SC_VBLANK;
        else               level = SC_LOW;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vblank_q <= 1'b0;
            sc_code  <= SC_LOW;
        end else begin
            if (line_start) vblank_q <= vb_now;
            sc_code <= level;
        end
    end

    assert_vb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(vblank_q));

    assert_hb_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_ext < POS_W'(HB_LEN)) |=> sc_code[1]);

    assert_burst_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_ext < POS_W'(BK_START)) |=> (sc_code != SC_BURST));

    assert_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_q && pos_ext < POS_W'(HB_LEN)) |=> (sc_code != SC_VBLANK));

endmodule

// File: rtl/vfield_timer.sv
module vfield_timer #(
    parameter int HPOS_W      = 10,
    parameter int CNT_W       = 10,
    parameter int WRAP        = 625,
    parameter int STD_THRESH  = 575,
    parameter int VD_DELAY_HL = 1,
    parameter int VD_LEN_HL   = 10,
    parameter int HB_LEN      = 118,
    parameter int BK_START    = 25,
    parameter int BK_LEN50    = 43,
    parameter int BK_LEN60    = 38,
    parameter int VB_POST50   = 45,
    parameter int VB_PRE50    = 5,
    parameter int VB_POST60   = 34,
    parameter int VB_PRE60    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hl_tick,
    input  logic              line_start,
    input  logic [HPOS_W-1:0] hpos,
    input  logic              vsync_q,
    output logic              vdrive,
    output logic              std50,
    output logic [1:0]        sc_code
);

    logic [CNT_W-1:0] hl_cnt;
    logic [CNT_W-1:0] prev_len;
    logic             field_start;

    vft_halfline_counter #(
        .CNT_W      (CNT_W),
        .WRAP       (WRAP),
        .STD_THRESH (STD_THRESH)
    ) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .hl_tick     (hl_tick),
        .vsync_q     (vsync_q),
        .hl_cnt      (hl_cnt),
        .prev_len    (prev_len),
        .std50       (std50),
        .field_start (field_start)
    );

    vft_vpulse_fsm #(
        .VD_DELAY_HL (VD_DELAY_HL),
        .VD_LEN_HL   (VD_LEN_HL)
    ) u_vpulse (
        .clk         (clk),
        .rst_n       (rst_n),
        .hl_tick     (hl_tick),
        .field_start (field_start),
        .vdrive      (vdrive)
    );

    vft_sandcastle #(
        .HPOS_W    (HPOS_W),
        .CNT_W     (CNT_W),
        .HB_LEN    (HB_LEN),
        .BK_START  (BK_START),
        .BK_LEN50  (BK_LEN50),
        .BK_LEN60  (BK_LEN60),
        .VB_POST50 (VB_POST50),
        .VB_PRE50  (VB_PRE50),
        .VB_POST60 (VB_POST60),
        .VB_PRE60  (VB_PRE60)
    ) u_sandcastle (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .hpos       (hpos),
        .hl_cnt     (hl_cnt),
        .prev_len   (prev_len),
        .std50      (std50),
        .sc_code    (sc_code)
    );

endmodule

// File: tb/vfield_timer_bench.sv
`timescale 1ns/1ps
module vfield_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hl_tick = 1'b0;
    logic       line_start = 1'b0;
    logic [9:0] hpos = 10'd600;
    logic       vsync_q = 1'b0;
    logic       vdrive;
    logic       std50;
    logic [1:0] sc_code;

    int checks = 0;
    int errors = 0;

    // cycle model state
    int m_cnt = 0, m_std = 1, m_prev = 625, m_vst = 0, m_tc = 0, m_vb = 0, m_sc = 0;

    always #4 clk = ~clk;

    vfield_timer u_vfield_timer (
        .clk(clk), .rst_n(rst_n), .hl_tick(hl_tick), .line_start(line_start),
        .hpos(hpos), .vsync_q(vsync_q), .vdrive(vdrive), .std50(std50), .sc_code(sc_code)
    );

    function automatic int vb_fn(int cnt, int std, int prev);
        int post = std ? 45 : 34;
        int pre  = std ? 5 : 6;
        return ((cnt < post) || (cnt + pre >= prev)) ? 1 : 0;
    endfunction

    function automatic int sc_fn(int hp, int std, int vb);
        int bk_len = std ? 43 : 38;
        if (hp >= 25 && hp < 25 + bk_len) return 3;
        if (hp < 118) return 2;
        if (vb != 0) return 1;
        return 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        int vs = vsync_q, tk = hl_tick, ls = line_start, hp = int'(hpos);
        int wrap = (tk && !vs && m_cnt == 624) ? 1 : 0;
        int fs = (vs || wrap) ? 1 : 0;
        int n_cnt = m_cnt, n_std = m_std, n_prev = m_prev;
        int n_vst = m_vst, n_tc = m_tc, n_vb = m_vb, n_sc;
        if (vs) begin n_prev = m_cnt; n_std = (m_cnt >= 575); n_cnt = 0; end
        else if (wrap) begin n_cnt = 0; n_prev = 625; n_std = 1; end
        else if (tk) n_cnt = m_cnt + 1;
        if (fs) begin n_vst = 1; n_tc = 0; end
        else if (tk && m_vst == 1) begin
            if (m_tc == 0) begin n_vst = 2; n_tc = 0; end else n_tc = m_tc + 1;
        end else if (tk && m_vst == 2) begin
            if (m_tc == 9) begin n_vst = 0; n_tc = 0; end else n_tc = m_tc + 1;
        end
        if (ls) n_vb = vb_fn(m_cnt, m_std, m_prev);
        n_sc = sc_fn(hp, m_std, m_vb);
        @(posedge clk);
        @(negedge clk);
        m_cnt = n_cnt; m_std = n_std; m_prev = n_prev;
        m_vst = n_vst; m_tc = n_tc; m_vb = n_vb; m_sc = n_sc;
        chk("R5 vdrive model", int'(vdrive), (m_vst == 2) ? 1 : 0);
        chk("R3 std50 model", int'(std50), m_std);
        if (m_sc == 3)      chk(m_vb ? "R10 burst over vblank" : "R8 burst key", int'(sc_code), m_sc);
        else if (m_sc == 2) chk(m_vb ? "R10 hblank over vblank" : "R7 hblank", int'(sc_code), m_sc);
        else                chk("R9 vblank level", int'(sc_code), m_sc);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            hl_tick = 1'b1; step(); hl_tick = 1'b0;
        end
    endtask

    task automatic vs_pulse(input bit with_tick);
        vsync_q = 1'b1; hl_tick = with_tick; step();
        vsync_q = 1'b0; hl_tick = 1'b0;
    endtask

    task automatic line_pulse();
        line_start = 1'b1; step(); line_start = 1'b0;
    endtask

    task automatic probe(input int hp, input int exp, input string req);
        hpos = 10'(hp); step();
        chk(req, int'(sc_code), exp);
        hpos = 10'd600;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1207));
        repeat (3) @(negedge clk);
        chk("R5 reset vdrive", int'(vdrive), 0);
        chk("R3 reset std50", int'(std50), 1);
        chk("R6 reset sc_code", int'(sc_code), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R3 boundary of the field length
        vs_pulse(0); tick_n(574); vs_pulse(0);
        chk("R1 574 half-lines gives 60 Hz", int'(std50), 0);
        tick_n(575); vs_pulse(0);
        chk("R3 575 half-lines gives 50 Hz", int'(std50), 1);

        // R2 sync wins over tick in the same cycle
        vs_pulse(1); tick_n(574); vs_pulse(0);
        chk("R2 tick with sync not counted", int'(std50), 0);

        // R4 forced wrap
        tick_n(624);
        chk("R4 before wrap still 60 Hz", int'(std50), 0);
        tick_n(1);
        chk("R4 wrap forces 50 Hz", int'(std50), 1);
        chk("R4 wrap holds vdrive low", int'(vdrive), 0);
        tick_n(1);
        chk("R4 wrap starts vertical pulse", int'(vdrive), 1);

        // R5 pulse timing
        vs_pulse(0);
        chk("R5 field start forces low", int'(vdrive), 0);
        tick_n(1);
        chk("R5 high after first tick", int'(vdrive), 1);
        tick_n(9);
        chk("R5 still high after 9 more ticks", int'(vdrive), 1);
        tick_n(1);
        chk("R5 low after 10 ticks", int'(vdrive), 0);

        // R7 / R8 in 60 Hz mode
        tick_n(89); vs_pulse(0);
        chk("R3 short field gives 60 Hz", int'(std50), 0);
        probe(24, 2, "R7 hblank before burst");
        probe(25, 3, "R8 burst first position");
        probe(62, 3, "R8 burst last position 60 Hz");
        probe(63, 2, "R8 burst ends 60 Hz");
        probe(117, 2, "R7 hblank last position");
        probe(118, 0, "R7 hblank ends");

        // R8 in 50 Hz mode
        tick_n(600); vs_pulse(0);
        probe(67, 3, "R8 burst last position 50 Hz");
        probe(68, 2, "R8 burst ends 50 Hz");

        // R9 / R10 vertical blank windows, prev field = 600, 50 Hz
        line_pulse();
        probe(200, 1, "R9 vblank after field start");
        probe(30, 3, "R10 burst beats vblank");
        probe(100, 2, "R10 hblank beats vblank");
        tick_n(45);
        probe(200, 1, "R9 vblank held without line start");
        line_pulse();
        probe(200, 0, "R9 vblank ends at 45 half-lines");
        tick_n(549); line_pulse();
        probe(200, 0, "R9 no pre-blank at 594 of 600");
        tick_n(1); line_pulse();
        probe(200, 1, "R9 pre-blank at 595 of 600");

        // random traffic against the cycle model
        for (int i = 0; i < 20000; i++) begin
            vsync_q    = ($urandom % 2500) == 0;
            hl_tick    = ($urandom % 2) == 0;
            line_start = ($urandom % 16) == 0;
            hpos       = 10'($urandom % 640);
            step();
        end
        vsync_q = 1'b0; hl_tick = 1'b0; line_start = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule